// File: doc/BRIEF.md
# SPI Slave with Deferred Low-Power Completion

This block is a serial peripheral interface slave with a 16-bit frame. The receive shifter is clocked by the external serial clock. Everything on the bus side runs on the system clock: the data register, the receive-full flag and the completion handshake. The bus side can be frozen by low-power requests while the shifter keeps running from the pins. A frame that finishes while the bus side is frozen is not reported at once. On exit from the frozen state, the frame is reported only if the select line was active at the moment of entry or at the moment of exit. A frame that starts and ends entirely inside an idle-to-idle frozen interval is dropped.

The bus side sees a single data register. A write stores the next word to transmit. A read returns the last frame that was posted. A read strobe clears the receive-full flag. Completion is handed to the bus clock by toggling a level in the serial-clock domain and passing it through a synchroniser. The captured frame is read only after the synchronised toggle has been seen. A non-retaining deep stop clears all bus-side state, and software must then set the block up again.

Top module: `spi_lp_slave`

## Requirements
- R1: Frames use clock mode 0 and are 16 bits long, sent MSB first. MOSI is sampled on the rising serial clock edge. After a frame completes, the data register holds the received word and the receive-full flag is 1.
- R2: MISO always carries the shifter MSB. At each frame end the shifter loads one of two words. If the data register has been written since reset or deep stop, it loads the written word. Otherwise it loads the frame just received, so the next frame echoes it.
- R3: After reset the data register reads 0 and the flag is 0. A read strobe clears the flag, unless a frame is posted in the same cycle.
- R4: The bus side halts whenever stop is 1, whatever the enable bit holds. Wait halts the bus side only when the wait-stop enable bit is 1. With the bit at 0, frames post normally during wait.
- R5: While the bus side is halted, the flag never changes and the data register never changes. A read strobe issued during the halt has no effect.
- R6: The shifter keeps receiving during a halt. If the select line (active low) was active at halt entry or at halt exit, the completed frame is posted on exit: the flag is set and the data register is loaded.
- R7: If the select line was idle at both halt entry and halt exit, any frame completed during the halt is dropped. The flag stays 0 and the data register keeps its previous value.
- R9: A deep-stop pulse clears the data register, the flag and the written-word state. No stale completion is posted afterwards, and MISO goes back to echoing received frames.
- R10: Raising the select line mid-frame clears the bit counter. A partial frame posts nothing, and the next full frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| wait_i | input | 1 | Wait request |
| stop_i | input | 1 | Retaining stop request |
| wait_en_i | input | 1 | Wait halts bus side when 1 |
| deep_stop_i | input | 1 | Non-retaining stop, clears state |
| we_i | input | 1 | Data register write strobe |
| wdata_i | input | 16 | Word to transmit |
| re_i | input | 1 | Data register read strobe, clears flag |
| rdata_o | output | 16 | Last posted received word |
| rxfull_o | output | 1 | Receive-full flag |

## Verification
The bench builds the block with its default 16-bit frame and a two-stage synchroniser, and runs the serial clock at one eighth of the bus clock rate. This leaves room for halt edges to land part-way through a frame. It covers entry while busy, exit while busy, and idle-to-idle intervals. It also covers stop with the wait-enable bit cleared, and a read strobe issued while halted. The two-stage latency is short compared with a serial bit, so posts can be checked at fixed settle points after the select line rises.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_POST,
    ACT_DROP,
    ACT_CLEAR
  } bus_act_e;

  function automatic logic halt_req(input logic wait_req, input logic stop_req,
                                    input logic wait_en);
    return stop_req | (wait_req & wait_en);
  endfunction

endpackage

// File: rtl/spi_lp_sync.sv
module spi_lp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/spi_lp_shifter.sv
module spi_lp_shifter #(
  parameter  int DATA_W = 16,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              tx_use_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] frame_o,
  output logic              done_tgl_o
);

  logic              cnt_clr;
  logic [CNT_W-1:0]  cnt_q;
  logic              rx_bit_q;
  logic [DATA_W-1:0] shift_q, frame_q, shift_nxt;
  logic              tgl_q;
  logic              frame_end;

  assign cnt_clr   = ss_ni | ~rst_ni | clr_i;
  assign shift_nxt = {shift_q[DATA_W-2:0], rx_bit_q};
  assign frame_end = (cnt_q == CNT_W'(DATA_W));

  // bit counter: counts rising edges, cleared while deselected
  always_ff @(posedge sck_i or posedge cnt_clr) begin
    if (cnt_clr)        cnt_q <= '0;
    else if (frame_end) cnt_q <= CNT_W'(1);
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge sck_i) rx_bit_q <= mosi_i;

  // shift on falling edge; at frame end reload for the next frame
  always_ff @(negedge sck_i) begin
    if (frame_end) begin
      frame_q <= shift_nxt;
      shift_q <= tx_use_i ? tx_word_i : shift_nxt;
    end else if (cnt_q != '0) begin
      shift_q <= shift_nxt;
    end
  end

  always_ff @(negedge sck_i or negedge rst_ni) begin
    if (!rst_ni)        tgl_q <= 1'b0;
    else if (frame_end) tgl_q <= ~tgl_q;
  end

  assign miso_o     = shift_q[DATA_W-1];
  assign frame_o    = frame_q;
  assign done_tgl_o = tgl_q;

  // R10
  always @(posedge sck_i) begin
    if (!cnt_clr) cnt_range_chk: assert (cnt_q <= CNT_W'(DATA_W));
  end

endmodule

// File: rtl/spi_lp_regs.sv
module spi_lp_regs
  import spi_lp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              deep_i,
  input  logic              tgl_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rxfull_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_use_o
);

  logic              seen_q, halted_q, entry_busy_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic              full_q, use_q;
  logic              pend_w, exit_w;
  bus_act_e          act;

  assign pend_w = (tgl_i != seen_q);
  assign exit_w = halted_q & ~halt_i;

  always_comb begin
    act = ACT_NONE;
    if (!halt_i) begin
      if (pend_w)    act = (exit_w && !entry_busy_q && !busy_i) ? ACT_DROP : ACT_POST;
      else if (re_i) act = ACT_CLEAR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q       <= 1'b0;
      halted_q     <= 1'b0;
      entry_busy_q <= 1'b0;
      rx_q         <= '0;
      tx_q         <= '0;
      full_q       <= 1'b0;
      use_q        <= 1'b0;
    end else if (deep_i) begin
      seen_q       <= tgl_i;  // realign so no stale completion posts
      halted_q     <= 1'b0;
      entry_busy_q <= 1'b0;
      rx_q         <= '0;
      tx_q         <= '0;
      full_q       <= 1'b0;
      use_q        <= 1'b0;
    end else begin
      halted_q <= halt_i;
      if (halt_i && !halted_q) entry_busy_q <= busy_i;
      case (act)
        ACT_POST: begin
          seen_q <= tgl_i;
          rx_q   <= frame_i;
          full_q <= 1'b1;
        end
        ACT_DROP:  seen_q <= tgl_i;
        ACT_CLEAR: full_q <= 1'b0;
        default: ;
      endcase
      if (!halt_i && we_i) begin
        tx_q  <= wdata_i;
        use_q <= 1'b1;
      end
    end
  end

  assign rdata_o   = rx_q;
  assign rxfull_o  = full_q;
  assign tx_word_o = tx_q;
  assign tx_use_o  = use_q;

  // R5
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !deep_i) |=> ($stable(rxfull_o) && $stable(rdata_o)));

  // R9
  deep_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_i |=> (rdata_o == '0 && !rxfull_o && !tx_use_o));

  // R3
  read_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !halt_i && !deep_i && (tgl_i == seen_q)) |=> !rxfull_o);

  // R7
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !halt_i && !deep_i && !entry_busy_q && !busy_i) |=> !$rose(rxfull_o));

  // R6
  defer_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !halt_i && !deep_i && (entry_busy_q || busy_i) && (tgl_i != seen_q))
      |=> rxfull_o);

endmodule

// File: rtl/spi_lp_slave.sv
module spi_lp_slave #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              wait_i,
  input  logic              stop_i,
  input  logic              wait_en_i,
  input  logic              deep_stop_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rxfull_o
);

  logic              halt;
  logic              tgl_raw, tgl_sync, ss_sync;
  logic [DATA_W-1:0] frame, tx_word;
  logic              tx_use;

  assign halt = spi_lp_pkg::halt_req(wait_i, stop_i, wait_en_i);

  spi_lp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .rst_ni    (rst_ni),
    .clr_i     (deep_stop_i),
    .sck_i     (sck_i),
    .ss_ni     (ss_ni),
    .mosi_i    (mosi_i),
    .tx_word_i (tx_word),
    .tx_use_i  (tx_use),
    .miso_o    (miso_o),
    .frame_o   (frame),
    .done_tgl_o(tgl_raw)
  );

  spi_lp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgl_raw),
    .q_o   (tgl_sync)
  );

  spi_lp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ss_ni),
    .q_o   (ss_sync)
  );

  spi_lp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt),
    .deep_i   (deep_stop_i),
    .tgl_i    (tgl_sync),
    .busy_i   (~ss_sync),
    .frame_i  (frame),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .re_i     (re_i),
    .rdata_o  (rdata_o),
    .rxfull_o (rxfull_o),
    .tx_word_o(tx_word),
    .tx_use_o (tx_use)
  );

endmodule

// File: tb/spi_lp_slave_tb_top.sv
module spi_lp_slave_tb_top;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ss_n = 1'b1, mosi = 1'b0, miso;
  logic        wait_r = 1'b0, stop_r = 1'b0, wait_en = 1'b0, deep = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        rxfull;
  logic [15:0] cap;
  int          checks = 0, errors = 0;
  bit          done_f = 1'b0;

  always #5 clk = ~clk;

  spi_lp_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .wait_i(wait_r), .stop_i(stop_r), .wait_en_i(wait_en),
    .deep_stop_i(deep), .we_i(we), .wdata_i(wdata), .re_i(re),
    .rdata_o(rdata), .rxfull_o(rxfull)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural monitor: while the bench-computed halt holds, outputs stay frozen (R5)
  bit          halt_edge = 1'b0;
  logic        pf = 1'b0;
  logic [15:0] pd = '0;
  always @(posedge clk) halt_edge = rst_n && !deep && (stop_r || (wait_r && wait_en));
  always @(negedge clk) begin
    if (halt_edge && !done_f) begin
      checks++;
      if (rxfull !== pf || rdata !== pd) begin
        errors++;
        $display("FAIL R5 halted outputs moved: actual %b/%h expected %b/%h", rxfull, rdata, pf, pd);
      end
    end
    pf = rxfull;
    pd = rdata;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ss_start();
    @(negedge clk);
    #2 ss_n = 1'b0;
    #40;
  endtask

  task automatic shift_bits(input logic [15:0] d, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      mosi = d[i];
      #20 cap[i] = miso;
      sck = 1'b1;
      #40 sck = 1'b0;
      #20;
    end
  endtask

  task automatic ss_end();
    #40 ss_n = 1'b1;
    idle(1);
  endtask

  task automatic frame(input logic [15:0] d);
    ss_start();
    shift_bits(d, 15, 0);
    ss_end();
    idle(8);
  endtask

  task automatic bus_read();
    @(negedge clk) re = 1'b1;
    @(negedge clk) re = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] v);
    @(negedge clk) begin we = 1'b1; wdata = v; end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_500_000;
    if (!done_f) begin
      done_f = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R3", "reset rdata", 32'(rdata), 32'h0);
    chk("R3", "reset flag", 32'(rxfull), 32'h0);

    // R1 basic receive
    frame(16'hA5C3);
    chk("R1", "flag after frame", 32'(rxfull), 32'h1);
    chk("R1", "rdata after frame", 32'(rdata), 32'hA5C3);
    bus_read();
    idle(1);
    chk("R3", "flag after read", 32'(rxfull), 32'h0);

    // R2 echo when nothing written
    frame(16'h1234);
    chk("R2", "miso echo", 32'(cap), 32'hA5C3);
    chk("R1", "rdata second", 32'(rdata), 32'h1234);
    bus_read();

    // R2 written word goes out one frame after the boundary load
    bus_write(16'hBEEF);
    frame(16'h0001);
    chk("R2", "miso before load", 32'(cap), 32'h1234);
    bus_read();
    frame(16'h0002);
    chk("R2", "miso written word", 32'(cap), 32'hBEEF);
    bus_read();

    // R10 partial frame aborted by select
    ss_start();
    shift_bits(16'hFFFF, 15, 11);
    ss_end();
    idle(8);
    chk("R10", "no flag after partial", 32'(rxfull), 32'h0);
    frame(16'h0F0F);
    chk("R10", "rdata after abort", 32'(rdata), 32'h0F0F);
    bus_read();

    // R4 wait with enable clear runs normally
    @(negedge clk) begin wait_r = 1'b1; wait_en = 1'b0; end
    frame(16'h3C3C);
    chk("R4", "flag in wait en=0", 32'(rxfull), 32'h1);
    chk("R4", "rdata in wait en=0", 32'(rdata), 32'h3C3C);
    bus_read();
    @(negedge clk) wait_r = 1'b0;

    // R7 idle entry and idle exit drops the frame
    @(negedge clk) begin wait_r = 1'b1; wait_en = 1'b1; end
    frame(16'h5555);
    @(negedge clk) wait_r = 1'b0;
    idle(8);
    chk("R7", "flag after idle exit", 32'(rxfull), 32'h0);
    chk("R7", "rdata after idle exit", 32'(rdata), 32'h3C3C);

    // R6 exit while busy posts
    @(negedge clk) wait_r = 1'b1;
    idle(4);
    ss_start();
    shift_bits(16'h6666, 15, 0);
    idle(8);
    chk("R5", "flag held in wait", 32'(rxfull), 32'h0);
    @(negedge clk) wait_r = 1'b0;
    idle(8);
    chk("R6", "flag on busy exit", 32'(rxfull), 32'h1);
    chk("R6", "rdata on busy exit", 32'(rdata), 32'h6666);
    ss_end();
    bus_read();

    // R6 entry while busy, stop with enable clear (R4)
    ss_start();
    shift_bits(16'h7E81, 15, 8);
    @(negedge clk) begin stop_r = 1'b1; wait_en = 1'b0; wait_r = 1'b1; end
    shift_bits(16'h7E81, 7, 0);
    ss_end();
    idle(8);
    chk("R4", "stop halts with en=0", 32'(rxfull), 32'h0);
    @(negedge clk) begin stop_r = 1'b0; wait_r = 1'b0; end
    idle(8);
    chk("R6", "flag on busy entry", 32'(rxfull), 32'h1);
    chk("R6", "rdata on busy entry", 32'(rdata), 32'h7E81);

    // R5 read strobe ignored while halted
    @(negedge clk) stop_r = 1'b1;
    idle(2);
    bus_read();
    idle(2);
    @(negedge clk) stop_r = 1'b0;
    idle(4);
    chk("R5", "read ignored in stop", 32'(rxfull), 32'h1);
    bus_read();
    idle(1);
    chk("R3", "flag cleared", 32'(rxfull), 32'h0);

    // R9 deep stop
    @(negedge clk) deep = 1'b1;
    @(negedge clk) deep = 1'b0;
    chk("R9", "rdata after deep", 32'(rdata), 32'h0);
    chk("R9", "flag after deep", 32'(rxfull), 32'h0);
    idle(4);
    chk("R9", "no stale post", 32'(rxfull), 32'h0);
    frame(16'h1357);
    bus_read();
    frame(16'h2468);
    chk("R9", "echo resumes", 32'(cap), 32'h1357);
    chk("R1", "rdata after deep", 32'(rdata), 32'h2468);

    done_f = 1'b1;
    summary();
    $finish;
  end

endmodule